// File: doc/BRIEF.md
# Non-Destructive Memory Size Prober

This block is a small bus-master engine that finds out whether RAM answers inside an address window, and how large that RAM is. It takes a one-cycle start pulse, a base byte address and a maximum window size that is a power of two. It then drives single-word reads and writes over a simple request/response memory port. When it finishes, it raises a one-cycle done pulse and reports the measured size in bytes. A size of zero means that no working RAM was found.

Only the first two words of the window are ever written. Their contents are read and saved before the first write, and they are written back before done rises. This holds whatever the outcome of the probe. The rest of the window, which may hold data that must survive, is only read.

Presence is tested twice, with two complementary bit patterns. Each time, the second word is written between the write of the first word and its read-back. This changes the value on the data bus, so a bus that merely holds the last value it carried cannot pass for memory. Size is then found by address aliasing. The engine reads the word at a probe offset and writes its complement to the base word. It then reads both words again. If they are equal, the probe address has wrapped onto the base, and that offset is the size. The probe offset starts at one word and doubles each step. The RAM size and the maximum size must both be powers of two.

Top module: `mem_size_probe`

## Requirements
- R1: After start, the first two requests are reads of the word at the base (offset 0) and of the word at offset 4 (one 32-bit word), and they come before any write.
- R2: The first presence test writes 0x5555AAAA to offset 0, then writes 0xAAAA5555 to offset 4, then reads offset 0. A read value other than 0x5555AAAA ends the probe with size 0.
- R3: The second presence test writes the two patterns swapped (0xAAAA5555 to offset 0, then 0x5555AAAA to offset 4) and reads offset 0 again. A read value other than 0xAAAA5555 ends the probe with size 0.
- R4: When RAM is present, the probe offset starts at 4 and doubles. At each offset the engine reads that word, writes its complement to offset 0, then reads offset 0 and the offset word. If the two reads are equal, the size is that offset.
- R5: When the probe offset reaches or exceeds the maximum size without a wrap, the reported size is the maximum size. This includes a maximum of 4, where no offset is probed.
- R6: No write request addresses any byte offset other than 0 or 4 within the window.
- R7: Before done rises, the saved words are written back to offsets 0 and 4, on every outcome, so the memory content is unchanged after the probe.
- R8: done_o is high for exactly one cycle per probe. While it is high, size_o is zero or a power of two, and no larger than the maximum size.
- R9: A start pulse that arrives while a probe is running is ignored. The running probe finishes with its own base and maximum, and only one done is produced.
- R10: A request stays valid with a stable address, direction and write data until it is accepted with req_ready_i. At most one request is outstanding at a time.
- R11: After reset, no request is valid, done_o is low and size_o is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that starts a probe while the engine is idle |
| base_i | input | AW | Byte address of the window base, word aligned |
| max_size_i | input | AW | Largest size in bytes to probe; a power of two, at least 4 |
| done_o | output | 1 | One-cycle pulse when a probe completes |
| size_o | output | AW | Measured size in bytes; 0 when no RAM was found |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted in this cycle |
| req_write_o | output | 1 | 1 for a write, 0 for a read |
| req_addr_o | output | AW | Request byte address |
| req_wdata_o | output | DW | Write data |
| rsp_valid_i | input | 1 | Read data valid; one response per read, arriving after acceptance |
| rsp_rdata_i | input | DW | Read data |

## Verification
The hardest state to reach from the ports is a presence check that fails only on the second, swapped pattern. A missing memory fails the first check, and good memory passes both. The bench reaches this state with a memory model in which bit 0 is stuck at zero. The first pattern has a zero in bit 0 and reads back correctly, while the swapped pattern reads back wrong. To cover the other outcomes, the memory model also imitates a bus that only holds the last written value, and RAM sizes smaller than, equal to and larger than the maximum size. Throughout, the acceptance signal is throttled, so every request must wait while held.

// File: rtl/mp_pkg.sv
package mp_pkg;

   // Steps of the probe sequence; the order follows the required access order.
   typedef enum logic [4:0] {
      ST_IDLE,
      ST_SAVE0,
      ST_SAVE1,
      ST_PA0,
      ST_PA1,
      ST_CKA,
      ST_PB0,
      ST_PB1,
      ST_CKB,
      ST_LIMIT,
      ST_RDT,
      ST_WINV,
      ST_RDB,
      ST_RDT2,
      ST_RST0,
      ST_RST1,
      ST_DONE
   } step_e;

   typedef enum logic [1:0] {
      BP_IDLE,
      BP_REQ,
      BP_RSP
   } bp_state_e;

endpackage

// File: rtl/mp_bus_port.sv
module mp_bus_port #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter bit WRITE_RSP = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_go,
   input  logic          op_write,
   input  logic [AW-1:0] op_addr,
   input  logic [DW-1:0] op_wdata,
   output logic          op_done,
   output logic [DW-1:0] op_rdata,
   output logic          req_valid_o,
   input  logic          req_ready_i,
   output logic          req_write_o,
   output logic [AW-1:0] req_addr_o,
   output logic [DW-1:0] req_wdata_o,
   input  logic          rsp_valid_i,
   input  logic [DW-1:0] rsp_rdata_i
);
   import mp_pkg::*;

   bp_state_e     st_q;
   logic          wr_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic          need_rsp;

   // Variant: whether a write also waits for a response beat.
   generate
      if (WRITE_RSP) begin : g_wr_rsp
         assign need_rsp = 1'b1;
      end else begin : g_wr_post
         assign need_rsp = ~wr_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= BP_IDLE;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         case (st_q)
            BP_IDLE: if (op_go) begin
               wr_q    <= op_write;
               addr_q  <= op_addr;
               wdata_q <= op_wdata;
               st_q    <= BP_REQ;
            end
            BP_REQ: if (req_ready_i) begin
               st_q <= need_rsp ? BP_RSP : BP_IDLE;
            end
            BP_RSP: if (rsp_valid_i) begin
               st_q <= BP_IDLE;
            end
            default: st_q <= BP_IDLE;
         endcase
      end
   end

   assign req_valid_o = (st_q == BP_REQ);
   assign req_write_o = wr_q;
   assign req_addr_o  = addr_q;
   assign req_wdata_o = wdata_q;
   assign op_done     = ((st_q == BP_REQ) && req_ready_i && !need_rsp)
                      || ((st_q == BP_RSP) && rsp_valid_i);
   assign op_rdata    = rsp_rdata_i;

endmodule

// File: rtl/mp_offset_gen.sv
module mp_offset_gen #(
   parameter int AW = 32,
   parameter int WB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init,
   input  logic          step,
   input  logic [AW-1:0] max_i,
   output logic [AW-1:0] ofs_o,
   output logic          at_limit_o
);
   localparam int OW = AW + 1;

   // One extra bit so doubling past the top of the address range never wraps.
   logic [OW-1:0] ofs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ofs_q <= OW'(WB);
      end else if (init) begin
         ofs_q <= OW'(WB);
      end else if (step) begin
         ofs_q <= {ofs_q[OW-2:0], 1'b0};
      end
   end

   assign ofs_o      = ofs_q[AW-1:0];
   assign at_limit_o = (ofs_q >= {1'b0, max_i});

endmodule

// File: rtl/mp_seq.sv
module mp_seq #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] max_i,
   output logic          op_go,
   output logic          op_write,
   output logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_wdata,
   input  logic          op_done,
   input  logic [DW-1:0] op_rdata,
   output logic          ofs_init,
   output logic          ofs_step,
   input  logic [AW-1:0] ofs_i,
   input  logic          at_limit_i,
   output logic          done_o,
   output logic [AW-1:0] size_o,
   output logic [AW-1:0] base_q_o,
   output logic [AW-1:0] max_q_o
);
   import mp_pkg::*;

   localparam int          WB    = DW / 8;
   localparam int          QW    = DW / 4;
   localparam logic [DW-1:0] PAT_A = {{QW{2'b01}}, {QW{2'b10}}};
   localparam logic [DW-1:0] PAT_B = ~PAT_A;

   step_e         step_q;
   logic [AW-1:0] base_q, max_q, size_q;
   logic [DW-1:0] save0_q, save1_q, t_q, b_q;
   logic [AW-1:0] addr_w1, addr_t;

   assign addr_w1 = base_q + AW'(WB);
   assign addr_t  = base_q + ofs_i;

   always_comb begin
      op_go    = 1'b1;
      op_write = 1'b0;
      op_addr  = base_q;
      op_wdata = '0;
      case (step_q)
         ST_SAVE0: op_addr = base_q;
         ST_SAVE1: op_addr = addr_w1;
         ST_PA0:   begin op_write = 1'b1; op_wdata = PAT_A; end
         ST_PA1:   begin op_write = 1'b1; op_addr = addr_w1; op_wdata = PAT_B; end
         ST_CKA:   op_addr = base_q;
         ST_PB0:   begin op_write = 1'b1; op_wdata = PAT_B; end
         ST_PB1:   begin op_write = 1'b1; op_addr = addr_w1; op_wdata = PAT_A; end
         ST_CKB:   op_addr = base_q;
         ST_RDT:   op_addr = addr_t;
         ST_WINV:  begin op_write = 1'b1; op_wdata = ~t_q; end
         ST_RDB:   op_addr = base_q;
         ST_RDT2:  op_addr = addr_t;
         ST_RST0:  begin op_write = 1'b1; op_wdata = save0_q; end
         ST_RST1:  begin op_write = 1'b1; op_addr = addr_w1; op_wdata = save1_q; end
         default:  op_go = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= ST_IDLE;
         base_q  <= '0;
         max_q   <= '0;
         size_q  <= '0;
         save0_q <= '0;
         save1_q <= '0;
         t_q     <= '0;
         b_q     <= '0;
      end else begin
         case (step_q)
            ST_IDLE: if (start_i) begin
               base_q <= base_i;
               max_q  <= max_i;
               size_q <= '0;
               step_q <= ST_SAVE0;
            end
            ST_SAVE0: if (op_done) begin save0_q <= op_rdata; step_q <= ST_SAVE1; end
            ST_SAVE1: if (op_done) begin save1_q <= op_rdata; step_q <= ST_PA0; end
            ST_PA0:   if (op_done) step_q <= ST_PA1;
            ST_PA1:   if (op_done) step_q <= ST_CKA;
            ST_CKA:   if (op_done) begin
               if (op_rdata != PAT_A) begin size_q <= '0; step_q <= ST_RST0; end
               else step_q <= ST_PB0;
            end
            ST_PB0:   if (op_done) step_q <= ST_PB1;
            ST_PB1:   if (op_done) step_q <= ST_CKB;
            ST_CKB:   if (op_done) begin
               if (op_rdata != PAT_B) begin size_q <= '0; step_q <= ST_RST0; end
               else step_q <= ST_LIMIT;
            end
            ST_LIMIT: begin
               if (at_limit_i) begin size_q <= max_q; step_q <= ST_RST0; end
               else step_q <= ST_RDT;
            end
            ST_RDT:   if (op_done) begin t_q <= op_rdata; step_q <= ST_WINV; end
            ST_WINV:  if (op_done) step_q <= ST_RDB;
            ST_RDB:   if (op_done) begin b_q <= op_rdata; step_q <= ST_RDT2; end
            ST_RDT2:  if (op_done) begin
               if (op_rdata == b_q) begin size_q <= ofs_i; step_q <= ST_RST0; end
               else step_q <= ST_LIMIT;
            end
            ST_RST0:  if (op_done) step_q <= ST_RST1;
            ST_RST1:  if (op_done) step_q <= ST_DONE;
            ST_DONE:  step_q <= ST_IDLE;
            default:  step_q <= ST_IDLE;
         endcase
      end
   end

   assign ofs_init = (step_q == ST_IDLE) && start_i;
   assign ofs_step = (step_q == ST_RDT2) && op_done && (op_rdata != b_q);
   assign done_o   = (step_q == ST_DONE);
   assign size_o   = size_q;
   assign base_q_o = base_q;
   assign max_q_o  = max_q;

endmodule

// File: rtl/mem_size_probe.sv
module mem_size_probe #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter bit WRITE_RSP = 1'b0
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] max_size_i,
   output logic          done_o,
   output logic [AW-1:0] size_o,
   output logic          req_valid_o,
   input  logic          req_ready_i,
   output logic          req_write_o,
   output logic [AW-1:0] req_addr_o,
   output logic [DW-1:0] req_wdata_o,
   input  logic          rsp_valid_i,
   input  logic [DW-1:0] rsp_rdata_i
);
   localparam int WB = DW / 8;

   generate
      if (DW < 16 || (DW % 16) != 0) begin : g_bad_dw
         $error("mem_size_probe: DW must be a multiple of 16");
      end
      if (AW < 4 || AW > 63) begin : g_bad_aw
         $error("mem_size_probe: AW must lie in 4..63");
      end
   endgenerate

   logic          op_go, op_write, op_done;
   logic [AW-1:0] op_addr;
   logic [DW-1:0] op_wdata, op_rdata;
   logic          ofs_init, ofs_step, at_limit;
   logic [AW-1:0] ofs;
   logic [AW-1:0] base_q, max_q;

   mp_seq #(.AW(AW), .DW(DW)) u_seq (
      .clk        (clk_i),
      .rst_n      (rst_ni),
      .start_i    (start_i),
      .base_i     (base_i),
      .max_i      (max_size_i),
      .op_go      (op_go),
      .op_write   (op_write),
      .op_addr    (op_addr),
      .op_wdata   (op_wdata),
      .op_done    (op_done),
      .op_rdata   (op_rdata),
      .ofs_init   (ofs_init),
      .ofs_step   (ofs_step),
      .ofs_i      (ofs),
      .at_limit_i (at_limit),
      .done_o     (done_o),
      .size_o     (size_o),
      .base_q_o   (base_q),
      .max_q_o    (max_q)
   );

   mp_offset_gen #(.AW(AW), .WB(WB)) u_ofs (
      .clk        (clk_i),
      .rst_n      (rst_ni),
      .init       (ofs_init),
      .step       (ofs_step),
      .max_i      (max_q),
      .ofs_o      (ofs),
      .at_limit_o (at_limit)
   );

   mp_bus_port #(.AW(AW), .DW(DW), .WRITE_RSP(WRITE_RSP)) u_port (
      .clk         (clk_i),
      .rst_n       (rst_ni),
      .op_go       (op_go),
      .op_write    (op_write),
      .op_addr     (op_addr),
      .op_wdata    (op_wdata),
      .op_done     (op_done),
      .op_rdata    (op_rdata),
      .req_valid_o (req_valid_o),
      .req_ready_i (req_ready_i),
      .req_write_o (req_write_o),
      .req_addr_o  (req_addr_o),
      .req_wdata_o (req_wdata_o),
      .rsp_valid_i (rsp_valid_i),
      .rsp_rdata_i (rsp_rdata_i)
   );

endmodule

// File: rtl/mp_probe_chk.sv
module mp_probe_chk #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          req_write,
   input logic [AW-1:0] req_addr,
   input logic [DW-1:0] req_wdata,
   input logic          done,
   input logic [AW-1:0] size,
   input logic [AW-1:0] base_q,
   input logic [AW-1:0] max_q
);
   localparam int WB = DW / 8;

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
                                     && $stable(req_write) && $stable(req_wdata)));

   // R6
   write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |-> ((req_addr == base_q) || (req_addr == base_q + AW'(WB))));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   size_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($countones(size) <= 1));

   // R8
   size_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (size <= max_q));

   // R9
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> $stable(base_q));

endmodule

bind mem_size_probe mp_probe_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk       (clk_i),
   .rst_n     (rst_ni),
   .req_valid (req_valid_o),
   .req_ready (req_ready_i),
   .req_write (req_write_o),
   .req_addr  (req_addr_o),
   .req_wdata (req_wdata_o),
   .done      (done_o),
   .size      (size_o),
   .base_q    (base_q),
   .max_q     (max_q)
);

// File: tb/sim_mem_size_probe.sv
`timescale 1ns/1ps
module sim_mem_size_probe;
   localparam int CLK_PERIOD = 10;
   localparam int WORDS      = 1024;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base = '0, max_size = '0;
   logic        done;
   logic [31:0] size;
   logic        req_valid, req_write;
   logic        req_ready = 1'b0;
   logic [31:0] req_addr, req_wdata;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_rdata = '0;

   int n_tests = 0, n_fail = 0, cycles = 0;

   // memory model state
   logic [31:0] mem  [0:WORDS-1];
   logic [31:0] snap [0:WORDS-1];
   int          act_words = 16;
   int          mode = 0;            // 0 RAM, 1 absent (bus holds last value), 2 bit0 stuck low
   logic [31:0] cur_base = '0;
   logic [31:0] bus_last = 32'h1234_5678;
   logic [3:0]  rdy_cnt = '0;

   // request monitor state
   int          op_n = 0, bad_wr = 0, hold_bad = 0, done_cnt = 0;
   logic        op_w [0:7];
   logic [31:0] op_off [0:7];
   logic [31:0] op_d [0:7];
   logic        pv = 1'b0, pr = 1'b0, pw = 1'b0;
   logic [31:0] pa = '0, pd = '0;

   mem_size_probe #(.AW(32), .DW(32)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base),
      .max_size_i(max_size), .done_o(done), .size_o(size),
      .req_valid_o(req_valid), .req_ready_i(req_ready), .req_write_o(req_write),
      .req_addr_o(req_addr), .req_wdata_o(req_wdata),
      .rsp_valid_i(rsp_valid), .rsp_rdata_i(rsp_rdata)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // memory model with throttled acceptance and one-cycle read latency
   always @(posedge clk) begin
      int idx;
      rdy_cnt   <= rdy_cnt + 4'd1;
      req_ready <= (rdy_cnt[1:0] != 2'b11);
      rsp_valid <= 1'b0;
      if (req_valid && req_ready) begin
         idx = int'(((req_addr - cur_base) >> 2)) & (act_words - 1);
         if (req_write) begin
            bus_last <= req_wdata;
            if (mode == 0) mem[idx] <= req_wdata;
            else if (mode == 2) mem[idx] <= req_wdata & 32'hFFFF_FFFE;
         end else begin
            rsp_valid <= 1'b1;
            rsp_rdata <= (mode == 1) ? bus_last : mem[idx];
            bus_last  <= (mode == 1) ? bus_last : mem[idx];
         end
      end
   end

   // request monitor
   always @(posedge clk) begin
      if (done) done_cnt++;
      if (rst_n && pv && !pr) begin
         if (!req_valid || req_addr != pa || req_write != pw || req_wdata != pd) hold_bad++;
      end
      if (req_valid && req_ready) begin
         if (op_n < 8) begin
            op_w[op_n]   = req_write;
            op_off[op_n] = req_addr - cur_base;
            op_d[op_n]   = req_wdata;
         end
         op_n++;
         if (req_write && (req_addr - cur_base) != 32'd0 && (req_addr - cur_base) != 32'd4)
            bad_wr++;
      end
      pv = req_valid; pr = req_ready; pw = req_write; pa = req_addr; pd = req_wdata;
   end

   task automatic report;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
            report();
            $finish;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic fill(input logic [31:0] seed, input bit even);
      for (int i = 0; i < WORDS; i++) begin
         mem[i] = (i * 32'h0101_0103) ^ seed;
         if (even) mem[i][0] = 1'b0;
         snap[i] = mem[i];
      end
   endtask

   // start a probe and wait for done; returns size and whether done arrived
   task automatic probe(input logic [31:0] b, input logic [31:0] m,
                        output logic [31:0] sz, output bit got);
      got = 1'b0;
      sz  = '0;
      @(negedge clk);
      cur_base = b;
      op_n = 0; bad_wr = 0; hold_bad = 0;
      base = b; max_size = m; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 40000; k++) begin
         @(negedge clk);
         if (done) begin got = 1'b1; sz = size; break; end
      end
      if (got) begin
         @(negedge clk);
         chk(!done, "R8 done one cycle", {31'd0, done}, 32'd0);
      end
   endtask

   task automatic check_restored(input string req);
      int diff = 0;
      for (int i = 0; i < act_words; i++) if (mem[i] !== snap[i]) diff++;
      chk(diff == 0, req, diff, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(!req_valid, "R11 reset req_valid", {31'd0, req_valid}, 32'd0);
      chk(!done, "R11 reset done", {31'd0, done}, 32'd0);
      chk(size == 32'd0, "R11 reset size", size, 32'd0);
   endtask

   task automatic t_ram(input int words, input logic [31:0] b, input logic [31:0] m,
                        input logic [31:0] seed);
      logic [31:0] sz, exp_sz;
      bit got;
      mode = 0; act_words = words; fill(seed, 1'b0);
      exp_sz = ((words * 4) < m) ? (words * 4) : m;
      probe(b, m, sz, got);
      chk(got, "R4 done arrives", {31'd0, got}, 32'd1);
      if ((words * 4) < m) chk(sz == exp_sz, "R4 wrap size", sz, exp_sz);
      else                 chk(sz == exp_sz, "R5 capped size", sz, exp_sz);
      chk(!op_w[0] && op_off[0] == 0, "R1 first read offset 0", op_off[0], 0);
      chk(!op_w[1] && op_off[1] == 4, "R1 second read offset 4", op_off[1], 4);
      chk(op_w[2] && op_off[2] == 0 && op_d[2] == 32'h5555_AAAA, "R2 pattern to offset 0", op_d[2], 32'h5555_AAAA);
      chk(op_w[3] && op_off[3] == 4 && op_d[3] == 32'hAAAA_5555, "R2 pattern to offset 4", op_d[3], 32'hAAAA_5555);
      chk(bad_wr == 0, "R6 writes only offsets 0 and 4", bad_wr, 0);
      chk(hold_bad == 0, "R10 request held until ready", hold_bad, 0);
      check_restored("R7 memory unchanged");
   endtask

   task automatic t_absent;
      logic [31:0] sz;
      bit got;
      mode = 1; act_words = 16; fill(32'h0F0F_0000, 1'b0);
      probe(32'h0003_0000, 32'd4096, sz, got);
      chk(got && sz == 32'd0, "R2 absent memory size 0", sz, 32'd0);
      chk(bad_wr == 0, "R6 absent writes in window", bad_wr, 0);
   endtask

   task automatic t_stuck;
      logic [31:0] sz;
      bit got;
      mode = 2; act_words = 64; fill(32'h7700_1100, 1'b1);
      probe(32'h0001_0000, 32'd4096, sz, got);
      chk(got && sz == 32'd0, "R3 swapped pattern fails size 0", sz, 32'd0);
      chk(op_n >= 8 && op_w[4] == 1'b0 && op_w[5] && op_d[5] == 32'hAAAA_5555,
          "R3 second check ran", op_d[5], 32'hAAAA_5555);
      check_restored("R7 restored after failed check");
   endtask

   task automatic t_busy;
      logic [31:0] sz;
      int d0;
      bit got;
      mode = 0; act_words = 16; fill(32'h5A5A_0000, 1'b0);
      d0 = done_cnt;
      @(negedge clk);
      cur_base = 32'h0001_0000; op_n = 0; bad_wr = 0;
      base = 32'h0001_0000; max_size = 32'd4096; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      base = 32'h0009_0000; max_size = 32'd8; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      got = 1'b0; sz = '0;
      for (int k = 0; k < 40000; k++) begin
         @(negedge clk);
         if (done) begin got = 1'b1; sz = size; break; end
      end
      repeat (100) @(negedge clk);
      chk(got && sz == 32'd64, "R9 busy start ignored size", sz, 32'd64);
      chk(done_cnt == d0 + 1, "R9 single done", done_cnt - d0, 1);
      check_restored("R9 R7 memory unchanged");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_ram(16,   32'h0001_0000, 32'd4096, 32'h1111_0000);   // 64 B behind a 4 KiB window
      t_ram(64,   32'h0002_0000, 32'd1024, 32'h2222_0000);   // 256 B
      t_ram(1024, 32'h0001_0000, 32'd4096, 32'h3333_0000);   // fills the window
      t_ram(1024, 32'h0004_0000, 32'd256,  32'h4444_0000);   // larger than window
      t_ram(16,   32'h0001_0000, 32'd4,    32'h5555_0000);   // smallest window, no probing
      t_absent();
      t_stuck();
      t_busy();
      report();
      $finish;
   end
endmodule